// File: doc/BRIEF.md
# Pipelined Binary Adder Tree

This block adds a fixed number of equal-width unsigned terms and returns their sum several cycles later. The terms arrive side by side on one packed input bus. A register stage captures them, and then a binary tree of registered two-input adders reduces them one level per clock. Every register runs on the single input clock.

The nodes are held in heap order. Index 1 is the root. Node i has its children at 2i and 2i+1. The leaves occupy indices BANK to 2·BANK−1. The sum is read from the root.

The pipeline accepts a new set of terms on every cycle, and the results leave in the order the sets entered. A valid bit runs alongside the data with the same delay, so the user knows which output cycles carry a result. The bank size must be a power of two of at least 2.

Top module: `adder_tree_pipe`

## Requirements
- R1: A clock edge with `rst` high clears every tree node and the valid pipeline. After that edge, `sum` reads 0 and `out_valid` reads 0, and `out_valid` stays 0 until a set presented with `in_valid` high has crossed the pipeline.
- R2: Term k is taken from bits [k·WORD +: WORD] of `terms_flat`. `sum` equals the total of all BANK terms, each treated as unsigned.
- R3: The total wraps modulo 2^WORD. A carry out of the top bit is discarded.
- R4: Terms presented before clock edge n appear on `sum` right after edge n+LATENCY−1, where LATENCY = 1 + log2(BANK) (4 edges for BANK = 8). `out_valid` appears after the same edge.
- R5: A new set of terms can be presented on every cycle. Consecutive sets produce consecutive results in the order they were presented.
- R6: `out_valid` is `in_valid` delayed by LATENCY edges. The data path sums whatever is on `terms_flat` whether or not `in_valid` is high, so `in_valid` affects only `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all registers |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the set of terms on `terms_flat` as meaningful |
| terms_flat | input | WORD·BANK | Packed terms; term k at bits [k·WORD +: WORD] |
| sum | output | WORD | Root of the tree: wrapped sum of a set presented LATENCY edges earlier |
| out_valid | output | 1 | `in_valid` delayed by LATENCY edges |

## Verification
The adder tree is driven with a set of patterns, each chosen to expose a different kind of fault:
- All zeros.
- A single nonzero term in the lowest lane.
- A single nonzero term in the highest lane. Together with the lowest-lane case, this exposes swapped or shifted lane slicing.
- An ascending ramp, which exposes a dropped or duplicated subtree.
- All ones and alternating 0xAAAA/0x5555 pairs, which force carries out of the top bit.
- A pair of 0x8000 terms plus one, which wraps exactly to 1.

These sets are streamed back to back to expose ordering faults and latency faults. A set held with `in_valid` low between two valid sets shows that valid tracks the data and that the data path does not gate on valid. A reset issued while data is in flight shows that both the nodes and the valid pipeline are cleared.

// File: rtl/addtree_pkg.sv
package addtree_pkg;

  // Number of adder levels between the leaves and the root.
  function automatic int tree_levels(input int bank);
    return $clog2(bank);
  endfunction

  // One capture stage plus one stage per adder level.
  function automatic int tree_latency(input int bank);
    return $clog2(bank) + 1;
  endfunction

endpackage

// File: rtl/at_leaf_bank.sv
module at_leaf_bank #(
  parameter int WORD = 16,
  parameter int BANK = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WORD*BANK-1:0] terms_flat,
  output logic [WORD*BANK-1:0] leaves
);

  // Each lane of the input bus gets its own capture register.
  for (genvar k = 0; k < BANK; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) leaves[k*WORD +: WORD] <= '0;
      else     leaves[k*WORD +: WORD] <= terms_flat[k*WORD +: WORD];
    end
  end

endmodule

// File: rtl/at_node_add.sv
module at_node_add #(
  parameter int WORD = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [WORD-1:0] lhs,
  input  logic [WORD-1:0] rhs,
  output logic [WORD-1:0] q
);

  // Two-input add whose carry out of the top bit is dropped.
  function automatic logic [WORD-1:0] wrap_sum(input logic [WORD-1:0] a,
                                               input logic [WORD-1:0] b);
    logic [WORD:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[WORD-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= wrap_sum(lhs, rhs);
  end

endmodule

// File: rtl/at_valid_pipe.sv
module at_valid_pipe #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) stage <= '0;
    else     stage <= {stage[DEPTH-2:0], din};
  end

  assign dout = stage[DEPTH-1];

endmodule

// File: rtl/adder_tree_pipe.sv
module adder_tree_pipe
  import addtree_pkg::*;
#(
  parameter int WORD = 16,
  parameter int BANK = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [WORD*BANK-1:0] terms_flat,
  output logic [WORD-1:0]      sum,
  output logic                 out_valid
);

  localparam int LEVELS  = tree_levels(BANK);
  localparam int LATENCY = tree_latency(BANK);
  localparam int NODES   = 2 * BANK;

  // Heap-ordered node storage: slot i lives at [i*WORD +: WORD], slot 0 is absent.
  logic [NODES*WORD-1:WORD] node_bus;

  // Root children, brought out by name for the checker.
  logic [WORD-1:0] root_left;
  logic [WORD-1:0] root_right;

  at_leaf_bank #(.WORD(WORD), .BANK(BANK)) u_leaves (
    .clk        (clk),
    .rst        (rst),
    .terms_flat (terms_flat),
    .leaves     (node_bus[NODES*WORD-1:BANK*WORD])
  );

  // Internal node i adds its children at 2i and 2i+1.
  for (genvar i = 1; i < BANK; i++) begin : g_node
    at_node_add #(.WORD(WORD)) u_add (
      .clk (clk),
      .rst (rst),
      .lhs (node_bus[(2*i)*WORD   +: WORD]),
      .rhs (node_bus[(2*i+1)*WORD +: WORD]),
      .q   (node_bus[i*WORD       +: WORD])
    );
  end

  at_valid_pipe #(.DEPTH(LATENCY)) u_valid (
    .clk  (clk),
    .rst  (rst),
    .din  (in_valid),
    .dout (out_valid)
  );

  assign root_left  = node_bus[2*WORD +: WORD];
  assign root_right = node_bus[3*WORD +: WORD];
  assign sum        = node_bus[WORD   +: WORD];

  if (LEVELS < 1) begin : g_bad_bank
    initial $error("BANK must be a power of two of at least 2");
  end

endmodule

// File: rtl/at_tree_chk.sv
module at_tree_chk #(
  parameter int WORD    = 16,
  parameter int BANK    = 8,
  parameter int LATENCY = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [WORD*BANK-1:0] terms_flat,
  input logic [WORD-1:0]      sum,
  input logic                 out_valid,
  input logic [WORD-1:0]      root_left,
  input logic [WORD-1:0]      root_right
);

  // Non-reset edges seen since the last reset, saturating at LATENCY.
  int unsigned     run_edges;
  logic [LATENCY-1:0] valid_shadow;
  logic [WORD-1:0] ref_now;
  logic [WORD-1:0] ref_pipe [LATENCY];

  always_comb begin
    ref_now = '0;
    for (int k = 0; k < BANK; k++) ref_now = ref_now + terms_flat[k*WORD +: WORD];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_edges    <= 0;
      valid_shadow <= '0;
      for (int s = 0; s < LATENCY; s++) ref_pipe[s] <= '0;
    end else begin
      if (run_edges < LATENCY) run_edges <= run_edges + 1;
      valid_shadow <= {valid_shadow[LATENCY-2:0], in_valid};
      ref_pipe[0]  <= ref_now;
      for (int s = 1; s < LATENCY; s++) ref_pipe[s] <= ref_pipe[s-1];
    end
  end

  // R1: the edge after a reset edge shows a cleared root and valid.
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sum == '0 && !out_valid));

  // R4 and R6: valid emerges exactly LATENCY edges after it entered.
  a_r4_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (run_edges >= LATENCY) |-> (out_valid == valid_shadow[LATENCY-1]));

  // R2 and R3: the root matches a wrapped reference total from LATENCY edges back.
  a_r2_sum_reference: assert property (@(posedge clk) disable iff (rst)
    (run_edges >= LATENCY) |-> (sum == ref_pipe[LATENCY-1]));

  // R5: the root is the previous-cycle wrapped sum of its two children.
  a_r5_root_children: assert property (@(posedge clk) disable iff (rst)
    (run_edges >= 1) |-> (sum == WORD'($past(root_left) + $past(root_right))));

endmodule

bind adder_tree_pipe at_tree_chk #(
  .WORD    (WORD),
  .BANK    (BANK),
  .LATENCY (LATENCY)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .terms_flat (terms_flat),
  .sum        (sum),
  .out_valid  (out_valid),
  .root_left  (root_left),
  .root_right (root_right)
);

// File: tb/adder_tree_pipe_tb.sv
`timescale 1ns/1ps
module adder_tree_pipe_tb;

  localparam int WORD = 16;
  localparam int BANK = 8;
  localparam int LAT  = 4;   // 1 capture stage + 3 adder levels for 8 terms
  localparam int NV   = 7;

  localparam logic [WORD*BANK-1:0] VEC [NV] = '{
    {128'h0},                                         // zeros
    {8{16'hFFFF}},                                    // carries out (R3)
    {16'h1234, 112'h0},                               // top lane only
    {16'd8, 16'd7, 16'd6, 16'd5, 16'd4, 16'd3, 16'd2, 16'd1},
    {80'h0, 16'h0001, 16'h8000, 16'h8000},            // exact wrap (R3)
    {4{16'hAAAA, 16'h5555}},                          // pairwise carries
    {112'h0, 16'h0007}                                // bottom lane only
  };
  localparam logic [WORD-1:0] EXP [NV] = '{
    16'h0000, 16'hFFF8, 16'h1234, 16'h0024, 16'h0001, 16'hFFFC, 16'h0007
  };

  logic                 clk = 1'b0;
  logic                 rst;
  logic                 in_valid;
  logic [WORD*BANK-1:0] terms_flat;
  logic [WORD-1:0]      sum;
  logic                 out_valid;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  adder_tree_pipe #(.WORD(WORD), .BANK(BANK)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .terms_flat (terms_flat),
    .sum        (sum),
    .out_valid  (out_valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; terms_flat = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset sum", 32'(sum), 32'h0);
    check("R1 reset valid", 32'(out_valid), 32'h0);

    // Table walk: back-to-back sets; result j seen at negedge j+LAT (R2 R3 R4 R5).
    for (int c = 0; c < NV + LAT; c++) begin
      if (c >= LAT) begin
        check("R2_R5 stream sum", 32'(sum), 32'(EXP[c-LAT]));
        check("R4_R6 stream valid", 32'(out_valid), 32'h1);
      end
      if (c < NV) begin terms_flat = VEC[c]; in_valid = 1'b1; end
      else        begin terms_flat = '0;     in_valid = 1'b0; end
      @(negedge clk);
    end
    check("R6 drained valid", 32'(out_valid), 32'h0);

    // Gap: valid, invalid-with-data, valid (R6); latency edge for first set (R4).
    for (int c = 0; c < 3 + LAT; c++) begin
      if (c == LAT - 1) check("R4 not yet valid", 32'(out_valid), 32'h0);
      if (c == LAT) begin
        check("R4 first valid", 32'(out_valid), 32'h1);
        check("R4 first sum", 32'(sum), 32'h0024);
      end
      if (c == LAT + 1) begin
        check("R6 gap valid low", 32'(out_valid), 32'h0);
        check("R6 gap data summed", 32'(sum), 32'h0007);
      end
      if (c == LAT + 2) begin
        check("R6 after gap valid", 32'(out_valid), 32'h1);
        check("R6 after gap sum", 32'(sum), 32'h1234);
      end
      case (c)
        0:       begin terms_flat = VEC[3]; in_valid = 1'b1; end
        1:       begin terms_flat = VEC[6]; in_valid = 1'b0; end
        2:       begin terms_flat = VEC[2]; in_valid = 1'b1; end
        default: begin terms_flat = '0;     in_valid = 1'b0; end
      endcase
      @(negedge clk);
    end

    // Reset with data in flight clears nodes and valid pipeline (R1).
    terms_flat = VEC[1]; in_valid = 1'b1;
    @(negedge clk);
    terms_flat = VEC[5];
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; terms_flat = '0; in_valid = 1'b0;
    check("R1 midstream sum", 32'(sum), 32'h0);
    check("R1 midstream valid", 32'(out_valid), 32'h0);
    for (int c = 0; c < LAT + 1; c++) begin
      @(negedge clk);
      check("R1 flushed valid", 32'(out_valid), 32'h0);
      check("R1 flushed sum", 32'(sum), 32'h0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule